// File: doc/BRIEF.md
# Byte-Masked Data Value Comparator

This block compares the data word of a load or store access against a reference word held by a debug unit. The word is split into four byte lanes, and each lane has its own enable. Each lane gives a single equality result. A two-bit mode then merges the lane results in one of three ways. In one mode, every enabled lane must agree. In another, any single enabled lane that agrees is enough. In the third, a whole halfword of enabled and agreeing lanes is required, and either halfword will do.

The merged result is sampled only for cycles in which the access strobe is high. It is returned one clock later as a single-cycle match pulse for the debug event logic. Address matching, status recording and interrupt delivery are handled elsewhere. The reference, mask and mode are plain inputs, held by the surrounding debug registers.

Top module: `dvc_data_match`

## Requirements
- R1: `hit` is high in the cycle after a clock edge at which `acc_valid` was high and the selected comparison passed. It stays high for exactly one cycle per such access, and it is low after any edge at which `acc_valid` was low.
- R2: Byte lane 0 is bits 31:24, lane 1 is bits 23:16, lane 2 is bits 15:8 and lane 3 is bits 7:0 of both `ref_value` and `acc_data`. Bit i of `lane_en` enables lane i.
- R3: With `combine_mode` = 2'b01 (all-lanes), the comparison passes when every lane is either disabled or has equal reference and data bytes. A differing byte in a disabled lane never blocks a match.
- R4: With `combine_mode` = 2'b10 (any-lane), the comparison passes when at least one lane is enabled and has equal bytes.
- R5: With `combine_mode` = 2'b11 (halfword), the comparison passes when lanes 0 and 1 are both enabled and both equal, or when lanes 2 and 3 are both enabled and both equal. Lane 3 is compared with data lane 3.
- R6: With `combine_mode` = 2'b00, no match is ever reported.
- R7: With `lane_en` = 4'b0000, every valid access matches in all-lanes mode, and no access matches in any-lane or halfword mode.
- R8: Halfword mode accepts every mask value and evaluates it by the R5 rule. For example, a mask that enables only lanes 1 and 2 never matches, and a mask that enables lanes 0, 1 and 2 matches when lanes 0 and 1 are equal.
- R9: While `rst_n` is low, and in the first cycle after its release, `hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| ref_value | input | 32 | Programmed reference word |
| lane_en | input | 4 | Per-byte-lane enable, bit i for lane i |
| combine_mode | input | 2 | 00 none, 01 all-lanes, 10 any-lane, 11 halfword |
| acc_data | input | 32 | Data word of the current access |
| acc_valid | input | 1 | Access strobe, qualifies `acc_data` |
| hit | output | 1 | Registered single-cycle match pulse |

## Verification
The only state in the block is the match register, so a fault shows at `hit` exactly one cycle after the access that caused it. A stuck or wrongly enabled register shows up in one of two ways: a pulse that lasts longer than one cycle, or a pulse after an idle cycle. A wrong lane slice or a wrong lane-to-enable mapping shows up as a wrong answer on the next cycle. The bench exposes it by changing the data in a single lane while only that lane is enabled, or only that lane is disabled. Each mode is driven with masks that separate the three merge rules, including an empty mask and halfword masks that are only partly filled.

// File: rtl/dvc_pkg.sv
package dvc_pkg;

  // How the per-lane equality results are merged.
  typedef enum logic [1:0] {
    MODE_NONE    = 2'b00,
    MODE_ALL     = 2'b01,
    MODE_ANY     = 2'b10,
    MODE_HALFWRD = 2'b11
  } combine_mode_e;

endpackage

// File: rtl/dvc_lane_cmp.sv
// Equality compare of one byte lane.
module dvc_lane_cmp #(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] ref_byte,
  input  logic [LANE_W-1:0] data_byte,
  output logic              equal
);

  always_comb begin
    equal = (ref_byte == data_byte);
  end

endmodule

// File: rtl/dvc_combine.sv
// Merges lane equality results under the selected mode.
module dvc_combine
  import dvc_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] lane_eq,
  input  logic [LANES-1:0] lane_en,
  input  logic [1:0]       mode,
  output logic             pass
);

  localparam int NPAIR = LANES / 2;

  logic [LANES-1:0] lane_ok;      // enabled and equal
  logic [LANES-1:0] lane_nonblk;  // disabled or equal
  logic [NPAIR-1:0] pair_ok;
  logic             all_ok;
  logic             any_ok;
  logic             half_ok;

  always_comb begin
    lane_ok     = lane_en & lane_eq;
    lane_nonblk = ~lane_en | lane_eq;
  end

  // One halfword per pair of adjacent lanes, lane 2p with lane 2p+1.
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    always_comb begin
      pair_ok[p] = lane_ok[2*p] & lane_ok[2*p+1];
    end
  end

  always_comb begin
    all_ok  = &lane_nonblk;
    any_ok  = |lane_ok;
    half_ok = |pair_ok;
  end

  always_comb begin
    unique case (combine_mode_e'(mode))
      MODE_ALL:     pass = all_ok;
      MODE_ANY:     pass = any_ok;
      MODE_HALFWRD: pass = half_ok;
      default:      pass = 1'b0;
    endcase
  end

endmodule

// File: rtl/dvc_hit_reg.sv
// Registers the qualified comparison into a single-cycle pulse.
module dvc_hit_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_valid,
  input  logic pass,
  output logic hit
);

  logic hit_q;
  logic hit_d;
  logic hit_en;

  // Load on an access; also load when set, so that the pulse clears.
  always_comb begin
    hit_en = acc_valid | hit_q;
    hit_d  = acc_valid & pass;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
    end else if (hit_en) begin
      hit_q <= hit_d;
    end
  end

  assign hit = hit_q;

endmodule

// File: rtl/dvc_data_match.sv
// Top: byte-masked data value comparator.
module dvc_data_match #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ref_value,
  input  logic [LANES-1:0]  lane_en,
  input  logic [1:0]        combine_mode,
  input  logic [DATA_W-1:0] acc_data,
  input  logic              acc_valid,
  output logic              hit
);

  logic [LANES-1:0] lane_eq;
  logic             pass;

  // Lane 0 is the most significant byte of the word.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int HI = DATA_W - 1 - i * LANE_W;
    dvc_lane_cmp #(.LANE_W(LANE_W)) u_cmp (
      .ref_byte  (ref_value[HI -: LANE_W]),
      .data_byte (acc_data[HI -: LANE_W]),
      .equal     (lane_eq[i])
    );
  end

  dvc_combine #(.LANES(LANES)) u_combine (
    .lane_eq (lane_eq),
    .lane_en (lane_en),
    .mode    (combine_mode),
    .pass    (pass)
  );

  dvc_hit_reg u_hit (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .pass      (pass),
    .hit       (hit)
  );

endmodule

// File: rtl/dvc_data_match_chk.sv
// Port-level properties of the comparator.
module dvc_data_match_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [LANES*LANE_W-1:0] ref_value,
  input logic [LANES-1:0]        lane_en,
  input logic [1:0]              combine_mode,
  input logic [LANES*LANE_W-1:0] acc_data,
  input logic                    acc_valid,
  input logic                    hit
);

  // R1: a pulse needs an access in the cycle before
  a_r1_hit_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(acc_valid));

  // R6: the undefined mode never produces a pulse
  a_r6_none_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ($past(combine_mode) != 2'b00));

  // R4: any-lane pulse needs at least one enabled lane
  a_r4_any_needs_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && $past(combine_mode) == 2'b10) |-> ($past(lane_en) != '0));

  // R5: halfword pulse needs a fully enabled lane pair
  a_r5_half_needs_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && $past(combine_mode) == 2'b11) |->
      (($past(lane_en[0]) && $past(lane_en[1])) ||
       ($past(lane_en[2]) && $past(lane_en[3]))));

  // R7: all-lanes with an empty mask always matches
  a_r7_empty_mask_all: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && combine_mode == 2'b01 && lane_en == '0) |=> hit);

  // R3: all-lanes with identical words always matches
  a_r3_equal_words_all: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && combine_mode == 2'b01 && acc_data == ref_value) |=> hit);

  // R9: output held low while reset is applied
  always @(negedge clk) begin
    if (!rst_n) begin
      a_r9_reset_low: assert (!hit);
    end
  end

endmodule

bind dvc_data_match dvc_data_match_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ref_value    (ref_value),
  .lane_en      (lane_en),
  .combine_mode (combine_mode),
  .acc_data     (acc_data),
  .acc_valid    (acc_valid),
  .hit          (hit)
);

// File: tb/test_dvc_data_match.sv
module test_dvc_data_match;

  localparam int HALF = 10;  // 50 MHz clock, 20 ns period

  logic        clk;
  logic        rst_n;
  logic [31:0] ref_value;
  logic [3:0]  lane_en;
  logic [1:0]  combine_mode;
  logic [31:0] acc_data;
  logic        acc_valid;
  logic        hit;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  item_t sb_q[$];

  dvc_data_match i_dvc_data_match (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_value    (ref_value),
    .lane_en      (lane_en),
    .combine_mode (combine_mode),
    .acc_data     (acc_data),
    .acc_valid    (acc_valid),
    .hit          (hit)
  );

  initial begin
    clk = 1'b0;
    forever #HALF clk = ~clk;
  end

  // Reference model written from the requirements.
  function automatic logic model(input logic [31:0] r, input logic [3:0] en,
                                 input logic [1:0] m, input logic [31:0] d,
                                 input logic v);
    logic [3:0] eq;
    logic [3:0] ok;
    for (int i = 0; i < 4; i++) begin
      eq[i] = (r[31-8*i -: 8] == d[31-8*i -: 8]);  // lane 0 = bits 31:24
    end
    ok = en & eq;
    if (!v) return 1'b0;
    case (m)
      2'b01:   return &(~en | eq);
      2'b10:   return |ok;
      2'b11:   return (ok[0] & ok[1]) | (ok[2] & ok[3]);
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: hit=%b expected=%b", tag, act, exp);
    end
  endtask

  // Driver: one access per cycle, expected result pushed to scoreboard.
  task automatic drive(input logic [31:0] r, input logic [3:0] en,
                       input logic [1:0] m, input logic [31:0] d,
                       input logic v, input string tag);
    item_t it;
    @(negedge clk);
    ref_value    = r;
    lane_en      = en;
    combine_mode = m;
    acc_data     = d;
    acc_valid    = v;
    it.exp = model(r, en, m, d, v);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compare a quarter period after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #(HALF/2);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(hit, it.exp, it.tag);
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 2 * HALF);
    checks++;
    errors++;
    $display("FAIL watchdog: hit=%b expected=run complete", hit);
    finish_run();
  end

  localparam logic [31:0] REF = 32'hAABB_CCDD;

  initial begin
    rst_n = 1'b0;
    ref_value = '0; lane_en = '0; combine_mode = '0; acc_data = '0; acc_valid = 1'b1;
    repeat (3) @(negedge clk);
    check(hit, 1'b0, "R9 during reset");
    rst_n = 1'b1;
    acc_valid = 1'b0;
    @(negedge clk);
    check(hit, 1'b0, "R9 after release");

    // R2: lane placement and enable mapping
    drive(REF, 4'b0001, 2'b01, 32'hAA00_0000, 1'b1, "R2 lane0 msb");
    drive(REF, 4'b1000, 2'b01, 32'hAA00_0000, 1'b1, "R2 lane3 lsb differs");
    drive(REF, 4'b1000, 2'b01, 32'h0000_00DD, 1'b1, "R2 lane3 lsb equal");
    drive(REF, 4'b0100, 2'b10, 32'h0000_CC00, 1'b1, "R2 lane2 any");
    // R3: all-lanes mode
    drive(REF, 4'b1111, 2'b01, REF,           1'b1, "R3 all equal");
    drive(REF, 4'b1111, 2'b01, 32'hAABB_CC00, 1'b1, "R3 one differs");
    drive(REF, 4'b0111, 2'b01, 32'hAABB_CC00, 1'b1, "R3 differing lane disabled");
    // R4: any-lane mode
    drive(REF, 4'b1111, 2'b10, 32'h0000_CC00, 1'b1, "R4 one lane equal");
    drive(REF, 4'b1011, 2'b10, 32'h0000_CC00, 1'b1, "R4 equal lane disabled");
    drive(REF, 4'b1111, 2'b10, 32'h1122_3344, 1'b1, "R4 none equal");
    // R5: halfword mode
    drive(REF, 4'b1111, 2'b11, 32'hAABB_0000, 1'b1, "R5 upper half");
    drive(REF, 4'b1111, 2'b11, 32'h0000_CCDD, 1'b1, "R5 lower half");
    drive(REF, 4'b1111, 2'b11, 32'hAA00_CC00, 1'b1, "R5 split lanes");
    drive(REF, 4'b1100, 2'b11, 32'h0000_CCDD, 1'b1, "R5 lower pair only");
    drive(REF, 4'b1111, 2'b11, 32'h0000_CCBB, 1'b1, "R5 lane3 vs data lane3");
    // R8: partial halfword masks
    drive(REF, 4'b0110, 2'b11, REF,           1'b1, "R8 lanes1,2 never");
    drive(REF, 4'b0111, 2'b11, 32'hAABB_CC00, 1'b1, "R8 lanes0-2 upper pair");
    drive(REF, 4'b1110, 2'b11, 32'hAABB_0000, 1'b1, "R8 lanes1-3 no pair");
    // R6: undefined mode
    drive(REF, 4'b1111, 2'b00, REF,           1'b1, "R6 none mode");
    drive(REF, 4'b0000, 2'b00, 32'h0,         1'b1, "R6 none mode empty mask");
    // R7: empty mask
    drive(REF, 4'b0000, 2'b01, 32'h1234_5678, 1'b1, "R7 all-lanes empty");
    drive(REF, 4'b0000, 2'b10, REF,           1'b1, "R7 any-lane empty");
    drive(REF, 4'b0000, 2'b11, REF,           1'b1, "R7 halfword empty");
    // R1: qualification and single-cycle pulse
    drive(REF, 4'b1111, 2'b01, REF,           1'b0, "R1 no access");
    drive(REF, 4'b1111, 2'b01, REF,           1'b1, "R1 back-to-back a");
    drive(REF, 4'b1111, 2'b01, REF,           1'b1, "R1 back-to-back b");
    drive(REF, 4'b1111, 2'b01, REF,           1'b0, "R1 pulse ends");
    drive(REF, 4'b0000, 2'b01, REF,           1'b0, "R1 idle stays low");
    drive(REF, 4'b1111, 2'b10, REF,           1'b1, "R1 after idle");
    drive(REF, 4'b1111, 2'b10, 32'h0,         1'b1, "R1 miss after hit");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule